// File: doc/BRIEF.md
# B8ZS Receive Decoder with Violation Flag

This block sits behind a line receiver's slicer and clock recovery. On each recovered-clock edge it takes one bit slot as a pair of rail bits: a positive-pulse bit and a negative-pulse bit. In single-rail mode it produces one active-low data output. It can remove B8ZS zero-substitution codes, and it raises a flag on any pulse that breaks the alternating polarity rule. A pulse inside a legal substitution code is not flagged. In dual-rail mode the rails pass straight through on two active-high outputs, and decoding and violation checks are off.

Every slot passes through an eight-slot history window, so decoded data leaves eight recovered-clock cycles after it is sampled. A substitution code is spotted only when the whole code sits in the window. The polarity reference is the polarity of the last pulse that left the window, so the check stays correct across removed codes.

A receive alarm control replaces the data with an all-ones signal. In single-rail mode the data output is held low. In dual-rail mode both rail outputs follow a divide-by-two of a separate alarm clock.

Top module: `b8zs_rx_decoder`

## Requirements
- R1: In single-rail mode with substitution off and no alarm, a slot sampled at recovered-clock edge k appears on `rx_data_n_o` just after edge k+8. The output is 0 for a pulse and 1 for an empty slot.
- R2: In single-rail mode a slot counts as a pulse only when exactly one rail bit is 1. Positive means `rail_pos_i`=1 and negative means `rail_neg_i`=1. Both rails at 1 is treated as an empty slot.
- R3: In single-rail mode `rx_aux_o` is 1 in exactly the output cycles whose pulse has the same polarity as the previous pulse that was kept. It is 0 in all other cycles.
- R4: After reset, the first pulse never raises `rx_aux_o`. No substitution code is recognised before that first pulse.
- R5: With `b8zs_en_i`=1 in single-rail mode, a run of eight slots (oldest first) empty, empty, empty, S, O, empty, O, S is output as eight empty slots and raises no flag. S is a pulse with the same polarity as the previous kept pulse, and O is a pulse with the opposite polarity.
- R6: With `b8zs_en_i`=0, that same run is output as pulses. The S pulse in its fourth slot and the O pulse in its seventh slot are both flagged.
- R7: A run with the empty slots in place but with pulse polarities that do not fit R5 is not replaced.
- R8: After a removed code, the polarity reference is the same as it was before the code.
- R9: With `dual_sel_i`=1 and no alarm, `rx_data_n_o` carries the positive rail and `rx_aux_o` carries the negative rail, both unchanged and with the R1 latency. Nothing is removed and nothing is flagged.
- R10: With `blue_rx_i`=1 in single-rail mode, `rx_data_n_o` stays 0 and `rx_aux_o` still follows R3.
- R11: With `blue_rx_i`=1 in dual-rail mode, both outputs are equal and flip on every rising edge of `blue_clk`.
- R12: While reset is held in single-rail mode with no alarm, `rx_data_n_o` is 1 and `rx_aux_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rec | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| rail_pos_i | input | 1 | Positive-pulse rail bit for the current slot |
| rail_neg_i | input | 1 | Negative-pulse rail bit for the current slot |
| b8zs_en_i | input | 1 | Enables substitution-code removal in single-rail mode |
| dual_sel_i | input | 1 | 1 selects dual-rail pass-through |
| blue_rx_i | input | 1 | Replaces receive data with the all-ones alarm signal |
| blue_clk | input | 1 | Clock for the alarm signal, independent of `clk_rec` |
| rx_data_n_o | output | 1 | Single-rail: active-low data. Dual-rail: positive rail |
| rx_aux_o | output | 1 | Single-rail: violation flag. Dual-rail: negative rail |

## Verification
The polarity reference is the state that matters most. If it is wrong, every later pulse shows up on the flag pin inverted, starting from the next kept pulse, eight cycles after that pulse enters. A code that is missed or wrongly matched shows within the same eight-cycle latency. It appears either as four pulses with two flags where empty slots were expected, or as real data replaced by empty slots. The random streams mix legal codes, wrong-polarity codes and slots with both rails high. The directed cases cover a code arriving before any pulse and the flag on the first pulse after a removed code.

// File: rtl/b8zs_rx_pkg.sv
package b8zs_rx_pkg;

  localparam int CODE_LEN = 8;

  typedef struct packed {
    logic pos;
    logic neg;
  } rail_slot_t;

  // What the substitution code requires in each window slot.
  typedef enum logic [1:0] {
    K_EMPTY = 2'd0,
    K_SAME  = 2'd1,
    K_OPP   = 2'd2
  } slot_kind_t;

  function automatic logic slot_mark(rail_slot_t s);
    return s.pos ^ s.neg;
  endfunction

  // Slot 0 is the newest entry; slot CODE_LEN-1 is the oldest.
  function automatic slot_kind_t code_kind(int idx);
    case (idx)
      0:       return K_SAME;
      1:       return K_OPP;
      3:       return K_OPP;
      4:       return K_SAME;
      default: return K_EMPTY;
    endcase
  endfunction

  function automatic logic kind_hit(slot_kind_t k, rail_slot_t s, logic ref_neg);
    case (k)
      K_EMPTY: return !slot_mark(s);
      K_SAME:  return slot_mark(s) && (s.neg == ref_neg);
      default: return slot_mark(s) && (s.neg != ref_neg);
    endcase
  endfunction

endpackage

// File: rtl/b8zs_rx_rst_sync.sv
module b8zs_rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/b8zs_rx_window.sv
module b8zs_rx_window
  import b8zs_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pos_i,
  input  logic       neg_i,
  input  logic       code_on_i,
  input  logic       ref_valid_i,
  input  logic       ref_neg_i,
  output rail_slot_t oldest_o,
  output logic       code_hit_o
);

  rail_slot_t          win_q [CODE_LEN];
  rail_slot_t          win_d [CODE_LEN];
  logic [CODE_LEN-1:0] hit;
  logic                tail_busy;

  generate
    for (genvar k = 0; k < CODE_LEN; k++) begin : g_cmp
      assign hit[k] = kind_hit(code_kind(k), win_q[k], ref_neg_i);
    end
  endgenerate

  assign code_hit_o = code_on_i && ref_valid_i && (&hit);

  // Shift one slot per cycle; a recognised code is wiped as it advances.
  always_comb begin
    win_d[0] = '{pos: pos_i, neg: neg_i};
    for (int k = 1; k < CODE_LEN; k++) begin
      win_d[k] = code_hit_o ? '0 : win_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CODE_LEN; k++) win_q[k] <= '0;
    end else begin
      for (int k = 0; k < CODE_LEN; k++) win_q[k] <= win_d[k];
    end
  end

  assign oldest_o = win_q[CODE_LEN-1];

  always_comb begin
    tail_busy = 1'b0;
    for (int k = 1; k < CODE_LEN; k++) tail_busy = tail_busy | win_q[k].pos | win_q[k].neg;
  end

  // R5: once a code is recognised, every older slot it occupied is empty next cycle
  a_r5_code_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    code_hit_o |=> !tail_busy);

endmodule

// File: rtl/b8zs_rx_out_stage.sv
module b8zs_rx_out_stage
  import b8zs_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rail_slot_t slot_i,
  input  logic       dual_i,
  output logic       out_pos_o,
  output logic       out_neg_o,
  output logic       vio_o,
  output logic       ref_valid_o,
  output logic       ref_neg_o
);

  logic pos_q, neg_q, vio_q, ref_valid_q, ref_neg_q;
  logic vio_d, ref_valid_d, ref_neg_d;
  logic mark_in;

  assign mark_in = slot_mark(slot_i);

  always_comb begin
    vio_d       = 1'b0;
    ref_valid_d = ref_valid_q;
    ref_neg_d   = ref_neg_q;
    if (!dual_i && mark_in) begin
      vio_d       = ref_valid_q && (slot_i.neg == ref_neg_q);
      ref_valid_d = 1'b1;
      ref_neg_d   = slot_i.neg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= 1'b0;
      neg_q       <= 1'b0;
      vio_q       <= 1'b0;
      ref_valid_q <= 1'b0;
      ref_neg_q   <= 1'b0;
    end else begin
      pos_q       <= slot_i.pos;
      neg_q       <= slot_i.neg;
      vio_q       <= vio_d;
      ref_valid_q <= ref_valid_d;
      ref_neg_q   <= ref_neg_d;
    end
  end

  assign out_pos_o   = pos_q;
  assign out_neg_o   = neg_q;
  assign vio_o       = vio_q;
  assign ref_valid_o = ref_valid_q;
  assign ref_neg_o   = ref_neg_q;

  // R4: the pulse that first sets the reference is never flagged
  a_r4_first_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_valid_q) |-> !vio_q);

  // R8: slots without a pulse leave the polarity reference alone
  a_r8_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mark_in |=> $stable(ref_neg_q));

  // R9: no flag while in dual-rail mode
  a_r9_dual_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dual_i |=> !vio_q);

endmodule

// File: rtl/b8zs_rx_blue_gen.sv
module b8zs_rx_blue_gen (
  input  logic clk,
  input  logic rst_n,
  output logic tgl_o
);

  logic tgl_q;
  logic tgl_d;

  always_comb tgl_d = !tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_d;
  end

  assign tgl_o = tgl_q;

  // R11: the alarm pattern changes on every alarm-clock edge
  a_r11_blue_flips: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tgl_q != $past(tgl_q)));

endmodule

// File: rtl/b8zs_rx_decoder.sv
module b8zs_rx_decoder
  import b8zs_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_rec,
  input  logic rst_n,
  input  logic rail_pos_i,
  input  logic rail_neg_i,
  input  logic b8zs_en_i,
  input  logic dual_sel_i,
  input  logic blue_rx_i,
  input  logic blue_clk,
  output logic rx_data_n_o,
  output logic rx_aux_o
);

  logic       rst_core_n, rst_blue_n;
  rail_slot_t oldest;
  logic       code_hit, code_on;
  logic       out_pos, out_neg, vio, ref_valid, ref_neg;
  logic       blue_tgl;

  b8zs_rx_rst_sync #(.STAGES(SYNC_STAGES)) i_sync_core (
    .clk(clk_rec), .rst_async_n(rst_n), .rst_sync_n(rst_core_n));

  b8zs_rx_rst_sync #(.STAGES(SYNC_STAGES)) i_sync_blue (
    .clk(blue_clk), .rst_async_n(rst_n), .rst_sync_n(rst_blue_n));

  assign code_on = b8zs_en_i && !dual_sel_i;

  b8zs_rx_window i_window (
    .clk(clk_rec), .rst_n(rst_core_n),
    .pos_i(rail_pos_i), .neg_i(rail_neg_i),
    .code_on_i(code_on), .ref_valid_i(ref_valid), .ref_neg_i(ref_neg),
    .oldest_o(oldest), .code_hit_o(code_hit));

  b8zs_rx_out_stage i_out (
    .clk(clk_rec), .rst_n(rst_core_n),
    .slot_i(oldest), .dual_i(dual_sel_i),
    .out_pos_o(out_pos), .out_neg_o(out_neg), .vio_o(vio),
    .ref_valid_o(ref_valid), .ref_neg_o(ref_neg));

  b8zs_rx_blue_gen i_blue (
    .clk(blue_clk), .rst_n(rst_blue_n), .tgl_o(blue_tgl));

  always_comb begin
    if (dual_sel_i) begin
      rx_data_n_o = blue_rx_i ? blue_tgl : out_pos;
      rx_aux_o    = blue_rx_i ? blue_tgl : out_neg;
    end else begin
      rx_data_n_o = blue_rx_i ? 1'b0 : !(out_pos ^ out_neg);
      rx_aux_o    = vio;
    end
  end

  // R5: the cycle after a code is recognised shows an empty, unflagged slot
  a_r5_code_silent: assert property (@(posedge clk_rec) disable iff (!rst_core_n)
    code_hit |=> (!vio && !(out_pos ^ out_neg)));

endmodule

// File: tb/test_b8zs_rx_decoder.sv
module test_b8zs_rx_decoder;

  localparam int CLK_PERIOD  = 10;
  localparam int BLUE_PERIOD = 14;
  localparam int MAXN        = 512;

  logic clk_rec = 1'b0;
  logic blue_clk = 1'b0;
  logic rst_n, rail_pos_i, rail_neg_i, b8zs_en_i, dual_sel_i, blue_rx_i;
  logic rx_data_n_o, rx_aux_o;

  int n_checks = 0;
  int n_fail   = 0;

  logic sp [MAXN];
  logic sn [MAXN];
  logic ed [MAXN];
  logic ev [MAXN];

  always #(CLK_PERIOD/2)  clk_rec  = !clk_rec;
  always #(BLUE_PERIOD/2) blue_clk = !blue_clk;

  b8zs_rx_decoder i_b8zs_rx_decoder (
    .clk_rec(clk_rec), .rst_n(rst_n),
    .rail_pos_i(rail_pos_i), .rail_neg_i(rail_neg_i),
    .b8zs_en_i(b8zs_en_i), .dual_sel_i(dual_sel_i),
    .blue_rx_i(blue_rx_i), .blue_clk(blue_clk),
    .rx_data_n_o(rx_data_n_o), .rx_aux_o(rx_aux_o));

  task automatic check(logic act, logic exp, string tag, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic put_slot(int i, int kind);
    // kind: 0 empty, 1 positive, 2 negative, 3 both rails
    sp[i] = (kind == 1) || (kind == 3);
    sn[i] = (kind == 2) || (kind == 3);
  endtask

  task automatic put_code(int i, bit neg_ref);
    int s, o;
    s = neg_ref ? 2 : 1;
    o = neg_ref ? 1 : 2;
    put_slot(i, 0); put_slot(i+1, 0); put_slot(i+2, 0); put_slot(i+3, s);
    put_slot(i+4, o); put_slot(i+5, 0); put_slot(i+6, o); put_slot(i+7, s);
  endtask

  task automatic gen_rand(int from, int upto, int inj_pct);
    int i;
    i = from;
    while (i < upto) begin
      int r;
      r = $urandom % 100;
      if (r < inj_pct && i + 8 <= upto) begin
        put_code(i, bit'($urandom % 2));
        i += 8;
      end else begin
        r = $urandom % 100;
        if (r < 45)      put_slot(i, 0);
        else if (r < 52) put_slot(i, 3);
        else             put_slot(i, 1 + int'($urandom % 2));
        i++;
      end
    end
  endtask

  // Expected single-rail outputs from R2..R8.
  task automatic model(int n, bit b8on);
    logic wp [MAXN];
    logic wn [MAXN];
    logic ref_v, ref_n;
    for (int i = 0; i < MAXN; i++) begin
      wp[i] = (i < n) ? sp[i] : 1'b0;
      wn[i] = (i < n) ? sn[i] : 1'b0;
    end
    ref_v = 1'b0;
    ref_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (b8on && ref_v && i + 7 < n) begin
        bit ok;
        ok = 1'b1;
        for (int j = 0; j < 8; j++) begin
          logic mk;
          mk = wp[i+j] ^ wn[i+j];
          if (j == 3 || j == 7)      ok &= mk && (wn[i+j] == ref_n);
          else if (j == 4 || j == 6) ok &= mk && (wn[i+j] != ref_n);
          else                       ok &= !mk;
        end
        if (ok) for (int j = 0; j < 8; j++) begin wp[i+j] = 1'b0; wn[i+j] = 1'b0; end
      end
      ed[i] = !(wp[i] ^ wn[i]);
      ev[i] = (wp[i] ^ wn[i]) && ref_v && (wn[i] == ref_n);
      if (wp[i] ^ wn[i]) begin ref_v = 1'b1; ref_n = wn[i]; end
    end
  endtask

  task automatic do_reset(bit dual, bit b8, bit blue);
    @(negedge clk_rec);
    rst_n = 1'b0; dual_sel_i = dual; b8zs_en_i = b8; blue_rx_i = blue;
    rail_pos_i = 1'b0; rail_neg_i = 1'b0;
    repeat (3) @(negedge clk_rec);
    if (!dual && !blue) begin
      check(rx_data_n_o, 1'b1, "R12", "data in reset");
      check(rx_aux_o, 1'b0, "R12", "flag in reset");
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk_rec);
  endtask

  task automatic stream(int n, bit dual, bit blue, string tag);
    rail_pos_i = sp[0]; rail_neg_i = sn[0];
    for (int t = 0; t < n + 8; t++) begin
      @(posedge clk_rec);
      @(negedge clk_rec);
      if (t >= 8) begin
        int k;
        k = t - 8;
        if (dual) begin
          check(rx_data_n_o, sp[k], tag, "pos rail");
          check(rx_aux_o, sn[k], tag, "neg rail");
        end else begin
          check(rx_data_n_o, blue ? 1'b0 : ed[k], tag, "data");
          check(rx_aux_o, ev[k], tag, "flag");
        end
      end else begin
        check(rx_data_n_o, (dual || blue) ? 1'b0 : 1'b1, tag, "idle data");
        check(rx_aux_o, 1'b0, tag, "idle flag");
      end
      rail_pos_i = (t + 1 < n) ? sp[t+1] : 1'b0;
      rail_neg_i = (t + 1 < n) ? sn[t+1] : 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rail_pos_i = 1'b0; rail_neg_i = 1'b0;
    b8zs_en_i = 1'b0; dual_sel_i = 1'b0; blue_rx_i = 1'b0;

    // R1 R3 R5 R7 R8: legal code, flag after it, wrong-polarity code, random tail
    do_reset(1'b0, 1'b1, 1'b0);
    put_slot(0, 1);
    put_code(1, 1'b0);
    put_slot(9, 1);
    put_slot(10, 2);
    put_code(11, 1'b0);
    n = 300;
    gen_rand(19, n, 15);
    model(n, 1'b1);
    stream(n, 1'b0, 1'b0, "R1 R3 R5 R7 R8");

    // R6 R2 R3: substitution off, codes pass as pulses with two flags
    do_reset(1'b0, 1'b0, 1'b0);
    n = 300;
    gen_rand(0, n, 20);
    model(n, 1'b0);
    stream(n, 1'b0, 1'b0, "R6 R2 R3");

    // R4: code shape before any pulse is kept, first pulse unflagged
    do_reset(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) put_slot(i, 0);
    put_code(5, 1'b0);
    n = 60;
    gen_rand(13, n, 20);
    model(n, 1'b1);
    stream(n, 1'b0, 1'b0, "R4");

    // R9 R2: dual-rail pass-through including both-rails slots
    do_reset(1'b1, 1'b1, 1'b0);
    n = 200;
    gen_rand(0, n, 20);
    stream(n, 1'b1, 1'b0, "R9 R2");

    // R10: single-rail alarm holds data low, flag unchanged
    do_reset(1'b0, 1'b1, 1'b1);
    n = 200;
    gen_rand(0, n, 15);
    model(n, 1'b1);
    stream(n, 1'b0, 1'b1, "R10");

    // R11: dual-rail alarm toggles with the alarm clock
    do_reset(1'b1, 1'b0, 1'b1);
    begin
      logic prev;
      prev = 1'b0;
      for (int j = 0; j < 12; j++) begin
        @(posedge blue_clk);
        #2;
        check(rx_aux_o, rx_data_n_o, "R11", "rails equal");
        if (j > 0) check(rx_data_n_o, !prev, "R11", "toggle");
        prev = rx_data_n_o;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule